// File: doc/BRIEF.md
# Snapshot-Read Event Counter Bank

This block holds a small bank of 20-bit event counters behind an 8-bit register port. Each counter advances by one on every cycle its event pulse is high while the bank is in run mode. It raises an increment interrupt pulse on every count and a wrap interrupt pulse when it rolls over from its all-ones value to zero. The counters have no reset, so a master reset leaves their contents in place. Software clears or presets them by writing bytes while the bank is in stop mode.

A counter is wider than the port, so it is read in three accesses. Reading the least significant byte returns it live. In the same cycle that read copies the counter's upper twelve bits into one holding register, which all counters share. Reads of the two upper byte positions at any counter's address return the holding register rather than the live counter. The three bytes therefore always come from a single instant, even while events keep arriving.

Each access is sampled on a clock edge. A small access state machine then spends one cycle in one of four states:

- PORT_IDLE: no request.
- PORT_READ: read data is presented.
- PORT_WRITE: a stop-mode byte load has been accepted.
- PORT_REJECT: a run-mode write has been refused.

From any state, the next state is chosen from the current request alone: none gives PORT_IDLE, a read gives PORT_READ, a write in stop mode gives PORT_WRITE, and a write in run mode gives PORT_REJECT.

Top module: `ectr_bank`

## Requirements
- R1: After reset, acc_rvalid, acc_err, inc_irq and wrap_irq are low, and the holding register is zero, so a read of byte 1 or byte 2 returns 0x00.
- R2: In run mode (stop_mode low), counter i increases by exactly one for each clock edge at which evt[i] is high.
- R3: A counter at 0xFFFFF that counts goes to 0x00000. Its wrap_irq bit is high for the cycle after that edge, and wrap_irq is never high without the matching inc_irq bit.
- R4: In run mode, inc_irq[i] is high for exactly the cycle after each edge at which evt[i] was high.
- R5: While stop_mode is high, no counter changes except through an accepted write, and inc_irq and wrap_irq stay low.
- R6: The address layout is as follows: acc_addr[3:2] selects the counter and acc_addr[1:0] selects the byte. Byte 3 holds bits 7:0, byte 2 holds bits 15:8, and byte 1 holds bits 19:16 in its low nibble with zeros above. A read of byte 3 returns the live low byte and copies bits 19:8 of that counter into the shared holding register. Reads of byte 1 or byte 2 at any counter address return the holding register.
- R7: Byte 0 of every counter reads as 0x00, and a write to byte 0 changes no counter.
- R8: In stop mode, a write to byte 1, 2 or 3 loads that byte of the addressed counter, in any order. A write to byte 1 keeps only the low four data bits.
- R9: A write in run mode is rejected. acc_err is high for the following cycle, and the counter does not change.
- R10: A master reset does not change any counter value.
- R11: acc_rvalid is high for exactly the cycle after each read request, with acc_rdata valid in that cycle. acc_err is high only after rejected writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low master reset (counters excluded) |
| stop_mode | input | 1 | High: stop mode (no counting, writes allowed) |
| evt | input | 4 | Event pulse per counter |
| acc_req | input | 1 | Access request, one per cycle |
| acc_wr | input | 1 | High for write, low for read |
| acc_addr | input | 4 | Counter index [3:2], byte select [1:0] |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Read data, valid with acc_rvalid |
| acc_rvalid | output | 1 | Read response strobe |
| acc_err | output | 1 | Rejected-write strobe |
| inc_irq | output | 4 | Per-counter increment pulse |
| wrap_irq | output | 4 | Per-counter wraparound pulse |

## Verification
The checker watches several rules on every cycle:

- each counter steps by exactly its event input in run mode;
- the counters freeze in stop mode unless a write arrives;
- interrupt pulses follow their events, and a wrap pulse never appears without an increment pulse;
- each read yields one response strobe, and each run-mode write yields exactly one error strobe with the counter untouched.

Other properties need the bench's scenarios to show them. These are the byte layout and nibble masking, the snapshot coherence across counters, byte-order independence of loads, and counter values surviving a master reset. The bench checks them with directed sequences and a seeded random run against a reference model.

// File: rtl/ectr_pkg.sv
package ectr_pkg;

    typedef enum logic [1:0] {
        PORT_IDLE,
        PORT_READ,
        PORT_WRITE,
        PORT_REJECT
    } port_state_e;

    localparam logic [1:0] BSEL_PAD = 2'd0;
    localparam logic [1:0] BSEL_HI  = 2'd1;
    localparam logic [1:0] BSEL_MID = 2'd2;
    localparam logic [1:0] BSEL_LO  = 2'd3;

endpackage

// File: rtl/ectr_counter.sv
module ectr_counter
    import ectr_pkg::*;
#(
    parameter int CTR_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             evt,
    input  logic             ld_en,
    input  logic [1:0]       ld_sel,
    input  logic [7:0]       ld_data,
    output logic [CTR_W-1:0] value,
    output logic             inc_flag,
    output logic             wrap_flag
);
    localparam int               TOP_W   = CTR_W - 16;
    localparam logic [CTR_W-1:0] CTR_MAX = '1;
    localparam logic [CTR_W-1:0] CTR_ONE = CTR_W'(1);

    logic count_now;
    assign count_now = run & evt;

    // Counter storage deliberately has no reset.
    always_ff @(posedge clk) begin
        if (ld_en) begin
            unique case (ld_sel)
                BSEL_HI:  value[CTR_W-1:16] <= ld_data[TOP_W-1:0];
                BSEL_MID: value[15:8]       <= ld_data;
                BSEL_LO:  value[7:0]        <= ld_data;
                default:  ;
            endcase
        end else if (count_now) begin
            value <= value + CTR_ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            inc_flag  <= 1'b0;
            wrap_flag <= 1'b0;
        end else begin
            inc_flag  <= count_now;
            wrap_flag <= count_now && (value == CTR_MAX);
        end
    end

endmodule

// File: rtl/ectr_port.sv
module ectr_port
    import ectr_pkg::*;
#(
    parameter int N      = 4,
    parameter int CTR_W  = 20,
    parameter int ADDR_W = $clog2(N) + 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    stop_mode,
    input  logic                    acc_req,
    input  logic                    acc_wr,
    input  logic [ADDR_W-1:0]       acc_addr,
    input  logic [N-1:0][CTR_W-1:0] values,
    output logic [N-1:0]            ld_en,
    output logic [7:0]              acc_rdata,
    output logic                    acc_rvalid,
    output logic                    acc_err
);
    localparam int HOLD_W = CTR_W - 8;
    localparam int PAD_W  = 24 - CTR_W;

    port_state_e        state_q, state_d;
    logic [HOLD_W-1:0]  hold_q;
    logic [ADDR_W-3:0]  idx;
    logic [1:0]         sel;
    logic [CTR_W-1:0]   sel_val;
    logic               rd_go, wr_go;

    assign idx     = acc_addr[ADDR_W-1:2];
    assign sel     = acc_addr[1:0];
    assign sel_val = values[idx];
    assign rd_go   = acc_req && !acc_wr;
    assign wr_go   = acc_req && acc_wr && stop_mode;

    always_comb begin
        ld_en = '0;
        if (wr_go) ld_en[idx] = 1'b1;
    end

    // next state
    always_comb begin
        if (!acc_req)       state_d = PORT_IDLE;
        else if (!acc_wr)   state_d = PORT_READ;
        else if (stop_mode) state_d = PORT_WRITE;
        else                state_d = PORT_REJECT;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PORT_IDLE;
        else        state_q <= state_d;
    end

    // outputs from state
    always_comb begin
        acc_rvalid = 1'b0;
        acc_err    = 1'b0;
        unique case (state_q)
            PORT_IDLE:   ;
            PORT_READ:   acc_rvalid = 1'b1;
            PORT_WRITE:  ;
            PORT_REJECT: acc_err = 1'b1;
        endcase
    end

    // read data and shared snapshot register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_rdata <= '0;
            hold_q    <= '0;
        end else if (rd_go) begin
            unique case (sel)
                BSEL_PAD: acc_rdata <= '0;
                BSEL_HI:  acc_rdata <= {{PAD_W{1'b0}}, hold_q[HOLD_W-1:8]};
                BSEL_MID: acc_rdata <= hold_q[7:0];
                BSEL_LO: begin
                    acc_rdata <= sel_val[7:0];
                    hold_q    <= sel_val[CTR_W-1:8];
                end
            endcase
        end
    end

endmodule

// File: rtl/ectr_bank.sv
module ectr_bank
    import ectr_pkg::*;
#(
    parameter int N      = 4,
    parameter int CTR_W  = 20,
    parameter int ADDR_W = $clog2(N) + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stop_mode,
    input  logic [N-1:0]      evt,
    input  logic              acc_req,
    input  logic              acc_wr,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [7:0]        acc_wdata,
    output logic [7:0]        acc_rdata,
    output logic              acc_rvalid,
    output logic              acc_err,
    output logic [N-1:0]      inc_irq,
    output logic [N-1:0]      wrap_irq
);
    logic [N-1:0][CTR_W-1:0] cnt_val;
    logic [N-1:0]            ld_en;

    ectr_port #(.N(N), .CTR_W(CTR_W), .ADDR_W(ADDR_W)) i_port (
        .clk        (clk),
        .rst_n      (rst_n),
        .stop_mode  (stop_mode),
        .acc_req    (acc_req),
        .acc_wr     (acc_wr),
        .acc_addr   (acc_addr),
        .values     (cnt_val),
        .ld_en      (ld_en),
        .acc_rdata  (acc_rdata),
        .acc_rvalid (acc_rvalid),
        .acc_err    (acc_err)
    );

    for (genvar g = 0; g < N; g++) begin : g_ctr
        ectr_counter #(.CTR_W(CTR_W)) i_ctr (
            .clk       (clk),
            .rst_n     (rst_n),
            .run       (!stop_mode),
            .evt       (evt[g]),
            .ld_en     (ld_en[g]),
            .ld_sel    (acc_addr[1:0]),
            .ld_data   (acc_wdata),
            .value     (cnt_val[g]),
            .inc_flag  (inc_irq[g]),
            .wrap_flag (wrap_irq[g])
        );
    end

endmodule

// File: rtl/ectr_bank_chk.sv
module ectr_bank_chk #(
    parameter int N      = 4,
    parameter int CTR_W  = 20,
    parameter int ADDR_W = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    stop_mode,
    input logic [N-1:0]            evt,
    input logic                    acc_req,
    input logic                    acc_wr,
    input logic                    acc_rvalid,
    input logic                    acc_err,
    input logic [N-1:0]            inc_irq,
    input logic [N-1:0]            wrap_irq,
    input logic [N-1:0][CTR_W-1:0] cnt_val
);
    for (genvar g = 0; g < N; g++) begin : g_chk
        assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
            !stop_mode |=> cnt_val[g] == CTR_W'($past(cnt_val[g]) + CTR_W'($past(evt[g]))));
    end

    assert_wrap_has_inc_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_irq & ~inc_irq) == '0);

    assert_inc_follows_evt_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !stop_mode |=> inc_irq == $past(evt));

    assert_stop_no_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
        stop_mode |=> (inc_irq == '0 && wrap_irq == '0));

    assert_stop_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_mode && !(acc_req && acc_wr)) |=> $stable(cnt_val));

    assert_reject_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_req && acc_wr && !stop_mode) |=> acc_err);

    assert_reject_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_req && acc_wr && !stop_mode && evt == '0) |=> $stable(cnt_val));

    assert_rvalid_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_req && !acc_wr) |=> acc_rvalid);

    assert_err_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
        acc_err |-> $past(acc_req && acc_wr && !stop_mode));

endmodule

bind ectr_bank ectr_bank_chk #(.N(N), .CTR_W(CTR_W), .ADDR_W(ADDR_W)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .stop_mode  (stop_mode),
    .evt        (evt),
    .acc_req    (acc_req),
    .acc_wr     (acc_wr),
    .acc_rvalid (acc_rvalid),
    .acc_err    (acc_err),
    .inc_irq    (inc_irq),
    .wrap_irq   (wrap_irq),
    .cnt_val    (cnt_val)
);

// File: tb/test_ectr_bank.sv
`timescale 1ns/1ps
module test_ectr_bank;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       stop_mode = 1'b1;
    logic [3:0] evt = '0;
    logic       acc_req = 1'b0;
    logic       acc_wr = 1'b0;
    logic [3:0] acc_addr = '0;
    logic [7:0] acc_wdata = '0;
    logic [7:0] acc_rdata;
    logic       acc_rvalid, acc_err;
    logic [3:0] inc_irq, wrap_irq;

    int checks = 0;
    int errors = 0;

    logic [19:0] m_cnt [4];
    logic [11:0] m_hold = '0;

    always #4 clk = ~clk;

    ectr_bank i_ectr_bank (.*);

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_byte(input logic [3:0] a);
        case (a[1:0])
            2'd0:    return 8'h00;
            2'd1:    return {4'h0, m_hold[11:8]};
            2'd2:    return m_hold[7:0];
            default: return m_cnt[a[3:2]][7:0];
        endcase
    endfunction

    function automatic logic [19:0] load_byte(input logic [19:0] v, input logic [1:0] s, input logic [7:0] d);
        logic [19:0] r = v;
        case (s)
            2'd1:    r[19:16] = d[3:0];
            2'd2:    r[15:8]  = d;
            2'd3:    r[7:0]   = d;
            default: ;
        endcase
        return r;
    endfunction

    task automatic step(input logic [3:0] ev, input logic rq, input logic w,
                        input logic [3:0] a, input logic [7:0] d, input string tag);
        logic       e_rv, e_err;
        logic [7:0] e_rd;
        logic [3:0] e_inc, e_wrap;
        evt = ev; acc_req = rq; acc_wr = w; acc_addr = a; acc_wdata = d;
        e_rv  = rq && !w;
        e_err = rq && w && !stop_mode;
        e_rd  = exp_byte(a);
        e_inc = stop_mode ? 4'h0 : ev;
        for (int i = 0; i < 4; i++) e_wrap[i] = e_inc[i] && (m_cnt[i] == 20'hFFFFF);
        if (e_rv && a[1:0] == 2'd3) m_hold = m_cnt[a[3:2]][19:8];
        if (rq && w && stop_mode) m_cnt[a[3:2]] = load_byte(m_cnt[a[3:2]], a[1:0], d);
        for (int i = 0; i < 4; i++) if (e_inc[i]) m_cnt[i] = m_cnt[i] + 20'd1;
        @(posedge clk);
        @(negedge clk);
        evt = '0; acc_req = 1'b0;
        check("R11 rvalid", acc_rvalid, e_rv);
        check("R9 err", acc_err, e_err);
        check("R4 inc_irq", inc_irq, e_inc);
        check("R3 wrap_irq", wrap_irq, e_wrap);
        if (e_rv) check(tag, acc_rdata, e_rd);
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d, input string tag);
        step(4'h0, 1'b1, 1'b1, a, d, tag);
    endtask

    task automatic rd(input logic [3:0] a, input string tag);
        step(4'h0, 1'b1, 1'b0, a, 8'h00, tag);
    endtask

    task automatic read_ctr(input int c, input string tag);
        rd(4'(c * 4 + 3), tag);
        rd(4'(c * 4 + 2), tag);
        rd(4'(c * 4 + 1), tag);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        m_hold = '0;
        @(negedge clk);
        check("R1 rvalid reset", acc_rvalid, 1'b0);
        check("R1 err reset", acc_err, 1'b0);
        check("R1 irq reset", {inc_irq, wrap_irq}, 8'h00);
    endtask

    initial begin
        void'($urandom(32'd4711));
        for (int i = 0; i < 4; i++) m_cnt[i] = '0;
        @(negedge clk);
        do_reset();
        rd(4'h1, "R1 hold byte1 after reset");
        rd(4'h2, "R1 hold byte2 after reset");

        // R8: loads in different byte orders, nibble masking
        wr(4'h3, 8'h5A, "R8"); wr(4'h2, 8'h3C, "R8"); wr(4'h1, 8'hF7, "R8");
        wr(4'h5, 8'h0E, "R8"); wr(4'h7, 8'h11, "R8"); wr(4'h6, 8'h22, "R8");
        wr(4'hA, 8'h80, "R8"); wr(4'h9, 8'h03, "R8"); wr(4'hB, 8'hFF, "R8");
        wr(4'hD, 8'h0A, "R8"); wr(4'hE, 8'hBC, "R8"); wr(4'hF, 8'hDE, "R8");
        for (int c = 0; c < 4; c++) read_ctr(c, "R8 R6 readback");
        rd(4'h1, "R6 nibble masked byte1 via hold");

        // R7: byte 0
        wr(4'h0, 8'hFF, "R7");
        wr(4'h4, 8'hAA, "R7");
        rd(4'h0, "R7 byte0 reads zero");
        rd(4'hC, "R7 byte0 reads zero");
        read_ctr(0, "R7 byte0 write ignored");
        read_ctr(1, "R7 byte0 write ignored");

        // R10: reset keeps counters
        do_reset();
        for (int c = 0; c < 4; c++) read_ctr(c, "R10 value after reset");

        // R9: run mode write rejected
        stop_mode = 1'b0;
        wr(4'h3, 8'h00, "R9");
        wr(4'h9, 8'h0F, "R9");
        read_ctr(0, "R9 unchanged");
        read_ctr(2, "R9 unchanged");

        // R3: wrap
        stop_mode = 1'b1;
        wr(4'hB, 8'hFE, "R3"); wr(4'hA, 8'hFF, "R3"); wr(4'h9, 8'h0F, "R3");
        stop_mode = 1'b0;
        step(4'h4, 1'b0, 1'b0, 4'h0, 8'h00, "R3");
        step(4'h4, 1'b0, 1'b0, 4'h0, 8'h00, "R3");
        step(4'h4, 1'b0, 1'b0, 4'h0, 8'h00, "R3");
        read_ctr(2, "R3 wrapped value");

        // R6: snapshot coherence across addresses
        rd(4'h7, "R6 low byte latch");
        for (int k = 0; k < 300; k++) step(4'h2, 1'b0, 1'b0, 4'h0, 8'h00, "R2");
        rd(4'hE, "R6 byte2 at other counter");
        rd(4'h1, "R6 byte1 at other counter");
        read_ctr(1, "R2 counted value");

        // R5: stop mode freezes
        stop_mode = 1'b1;
        for (int k = 0; k < 8; k++) step(4'hF, 1'b0, 1'b0, 4'h0, 8'h00, "R5");
        for (int c = 0; c < 4; c++) read_ctr(c, "R5 frozen");

        // random mix
        for (int k = 0; k < 4000; k++) begin
            logic       rq, w;
            logic [3:0] ev, a;
            if ($urandom_range(0, 49) == 0) stop_mode = ~stop_mode;
            ev = 4'($urandom_range(0, 15)) & 4'($urandom_range(0, 15));
            rq = ($urandom_range(0, 1) == 1);
            w  = ($urandom_range(0, 4) == 0);
            a  = 4'($urandom_range(0, 15));
            step(ev, rq, w, a, 8'($urandom_range(0, 255)), "R2 R6 R8 random read");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule